// File: doc/BRIEF.md
# Elevator Car Controller with Fire Override

This block sequences one elevator car. Each clock it compares the floor a request asks for with the floor the car's sensor reports. It then drives four Moore outputs: move up, move down, door open and door-timer start. After the car arrives, the door stays open until a dwell counter has seen a fixed number of timer ticks. The controller then falls back to its idle state, where the door is also open.

A fire input takes priority over all normal behaviour. While fire is asserted, the car descends until the sensor reports the first floor, with the door held shut. At the first floor it stops and opens the door. When fire drops, the controller resumes normal operation from idle. Request buttons, request arbitration, motor drive and floor sensing are all outside this block.

Top module: `lift_car_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in idle in normal mode. From the first clock after reset, the outputs read up=0, down=0, open=1, tstart=0.
- R2: In idle, with fire low and the requested floor equal to the current floor, the controller stays in idle with outputs up=0, down=0, open=1, tstart=0.
- R3: From idle, a requested floor above the current floor moves the controller to the up state on the next clock. The up state drives only up=1, and the controller remains there while the request stays above the current floor.
- R4: From idle, a requested floor below the current floor moves the controller to the down state on the next clock. The down state drives only down=1, and the controller remains there while the request stays below the current floor.
- R5: When the up or down state no longer sees its travel condition, the next clock enters the door state, which drives open=1 and tstart=1 with up=0 and down=0.
- R6: The dwell counter clears on entry to the door state and counts timer ticks sampled on clock edges while in that state. The door state is left for idle on the first edge at which 10 ticks have been counted. With tick held high this gives 11 door cycles. With no ticks the door state holds indefinitely.
- R7: up and down are never asserted together, and tstart is asserted only together with open.
- R8: Fire sampled high in any state moves the controller on that edge to the fire-descent state (down=1, open=0, up=0, tstart=0) when the current floor is not floor 1. When the current floor is floor 1, it moves instead to the fire-hold state (open=1 only).
- R9: In fire descent the car keeps down=1 while the floor is above 1 and passes to fire hold on the edge where the floor reads 1. Fire hold persists while fire stays high.
- R10: Fire sampled low while in a fire state returns the controller to idle in normal mode on that clock.
- R11: Floors are encoded as the 2-bit binary value of the floor number (1, 2, 3). The value 0, and any value above the configured floor count, is treated as the top floor (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_floor_i | input | FLOOR_W (2) | Requested floor, binary floor number |
| cur_floor_i | input | FLOOR_W (2) | Floor reported by the car sensor |
| fire_i | input | 1 | Fire override request |
| tick_i | input | 1 | Door timer tick |
| up_o | output | 1 | Drive car upward |
| down_o | output | 1 | Drive car downward |
| open_o | output | 1 | Door open |
| tstart_o | output | 1 | Door timer running |

## Verification
Directed runs cover several scenarios: equal floors, which must hold idle, and an upward trip and a downward trip, which separate the two travel states from each other and from arrival. Held-high and held-low ticks tell an exact eleven-cycle dwell apart from an indefinite one. Fire is raised at floors above one and at floor one, which separates descent from an immediate hold, and the out-of-range floor code 0 shows that it is read as the top floor. A long seeded random run then mixes requests, sensor values, sparse ticks and bursts of fire, and compares every output in every cycle against a bench-side reference model of the requirements.

// File: rtl/lift_pkg.sv
package lift_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_UP    = 3'd1,
      ST_DOWN  = 3'd2,
      ST_DOOR  = 3'd3,
      ST_FDESC = 3'd4,
      ST_FHOLD = 3'd5
   } lift_st_e;

   typedef struct packed {
      logic up;
      logic down;
      logic open;
      logic tstart;
   } lift_out_s;

endpackage

// File: rtl/lift_floor_norm.sv
module lift_floor_norm #(
   parameter int FLOOR_W    = 2,
   parameter int NUM_FLOORS = 3
) (
   input  logic [FLOOR_W-1:0] raw_i,
   output logic [FLOOR_W-1:0] norm_o
);
   localparam logic [FLOOR_W-1:0] TOP_FLOOR = FLOOR_W'(NUM_FLOORS);

   generate
      if (NUM_FLOORS < 2 || NUM_FLOORS > (1 << FLOOR_W) - 1) begin : g_bad_cfg
         $error("lift_floor_norm: NUM_FLOORS must lie in 2 .. 2**FLOOR_W-1");
      end
      if (NUM_FLOORS == (1 << FLOOR_W) - 1) begin : g_full_code
         // Every nonzero code is a real floor; only zero needs folding.
         assign norm_o = (raw_i == '0) ? TOP_FLOOR : raw_i;
      end else begin : g_part_code
         assign norm_o = ((raw_i == '0) || (raw_i > TOP_FLOOR)) ? TOP_FLOOR : raw_i;
      end
   endgenerate

endmodule

// File: rtl/lift_dwell_timer.sv
module lift_dwell_timer #(
   parameter int TMR_W       = 4,
   parameter int DWELL_TICKS = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic clear_i,
   input  logic run_i,
   input  logic tick_i,
   output logic done_o
);
   localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};
   localparam logic [TMR_W-1:0] DWELL   = TMR_W'(DWELL_TICKS);

   generate
      if (DWELL_TICKS < 1 || DWELL_TICKS >= (1 << TMR_W)) begin : g_bad_cfg
         $error("lift_dwell_timer: DWELL_TICKS must fit below 2**TMR_W");
      end
   endgenerate

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clear_i) begin
         cnt_q <= '0;
      end else if (run_i && tick_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = (cnt_q >= DWELL);

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_MAX && !clear_i) |=> (cnt_q == CNT_MAX)) else $error("dwell counter wrapped"); // R6

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
      clear_i |=> !done_o) else $error("dwell not cleared on entry"); // R6

endmodule

// File: rtl/lift_seq.sv
module lift_seq
   import lift_pkg::*;
#(
   parameter int FLOOR_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [FLOOR_W-1:0] req_i,
   input  logic [FLOOR_W-1:0] cur_i,
   input  logic               fire_i,
   input  logic               dwell_done_i,
   output logic               door_enter_o,
   output logic               door_run_o,
   output lift_out_s          out_o
);
   localparam logic [FLOOR_W-1:0] FLOOR_ONE = FLOOR_W'(1);

   lift_st_e st_q, st_d;
   logic     above, below, fire_mode;

   assign above     = (req_i > cur_i);
   assign below     = (req_i < cur_i);
   assign fire_mode = (st_q == ST_FDESC) || (st_q == ST_FHOLD);

   always_comb begin
      st_d = st_q;
      if (fire_i) begin
         st_d = (cur_i == FLOOR_ONE) ? ST_FHOLD : ST_FDESC;
      end else begin
         unique case (st_q)
            ST_IDLE:  st_d = above ? ST_UP : (below ? ST_DOWN : ST_IDLE);
            ST_UP:    st_d = above ? ST_UP : ST_DOOR;
            ST_DOWN:  st_d = below ? ST_DOWN : ST_DOOR;
            ST_DOOR:  st_d = dwell_done_i ? ST_IDLE : ST_DOOR;
            ST_FDESC: st_d = ST_IDLE;
            ST_FHOLD: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

   assign door_enter_o = (st_d == ST_DOOR) && (st_q != ST_DOOR);
   assign door_run_o   = (st_q == ST_DOOR);

   always_comb begin
      out_o = '0;
      unique case (st_q)
         ST_UP:    out_o.up   = 1'b1;
         ST_DOWN:  out_o.down = 1'b1;
         ST_FDESC: out_o.down = 1'b1;
         ST_DOOR:  begin out_o.open = 1'b1; out_o.tstart = 1'b1; end
         default:  out_o.open = 1'b1;
      endcase
   end

   AST_UP_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && !fire_i && above) |=> out_o.up) else $error("no up start"); // R3

   AST_DOWN_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && !fire_i && below) |=> out_o.down) else $error("no down start"); // R4

   AST_FIRE_SHUT: assert property (@(posedge clk) disable iff (rst)
      (fire_i && cur_i != FLOOR_ONE) |=> (out_o.down && !out_o.open)) else $error("fire descent wrong"); // R8

   AST_FIRE_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (fire_mode && !fire_i) |=> (st_q == ST_IDLE)) else $error("fire release wrong"); // R10

endmodule

// File: rtl/lift_car_ctrl.sv
module lift_car_ctrl
   import lift_pkg::*;
#(
   parameter int FLOOR_W     = 2,
   parameter int NUM_FLOORS  = 3,
   parameter int TMR_W       = 4,
   parameter int DWELL_TICKS = 10
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [FLOOR_W-1:0] req_floor_i,
   input  logic [FLOOR_W-1:0] cur_floor_i,
   input  logic               fire_i,
   input  logic               tick_i,
   output logic               up_o,
   output logic               down_o,
   output logic               open_o,
   output logic               tstart_o
);
   logic [FLOOR_W-1:0] req_n, cur_n;
   logic               door_enter, door_run, dwell_done;
   lift_out_s          outs;

   lift_floor_norm #(.FLOOR_W(FLOOR_W), .NUM_FLOORS(NUM_FLOORS)) u_req_norm (
      .raw_i (req_floor_i),
      .norm_o(req_n)
   );

   lift_floor_norm #(.FLOOR_W(FLOOR_W), .NUM_FLOORS(NUM_FLOORS)) u_cur_norm (
      .raw_i (cur_floor_i),
      .norm_o(cur_n)
   );

   lift_dwell_timer #(.TMR_W(TMR_W), .DWELL_TICKS(DWELL_TICKS)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .clear_i(door_enter),
      .run_i  (door_run),
      .tick_i (tick_i),
      .done_o (dwell_done)
   );

   lift_seq #(.FLOOR_W(FLOOR_W)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .req_i       (req_n),
      .cur_i       (cur_n),
      .fire_i      (fire_i),
      .dwell_done_i(dwell_done),
      .door_enter_o(door_enter),
      .door_run_o  (door_run),
      .out_o       (outs)
   );

   assign up_o     = outs.up;
   assign down_o   = outs.down;
   assign open_o   = outs.open;
   assign tstart_o = outs.tstart;

   AST_UPDOWN_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(up_o && down_o)) else $error("up and down together"); // R7

   AST_START_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
      tstart_o |-> open_o) else $error("timer start without open"); // R7

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (open_o && !up_o && !down_o && !tstart_o)) else $error("reset state wrong"); // R1

endmodule

// File: tb/lift_car_ctrl_tb.sv
module lift_car_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DWELL      = 10;

   localparam int M_IDLE = 0, M_UP = 1, M_DOWN = 2, M_DOOR = 3, M_FDESC = 4, M_FHOLD = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] req = 2'd1;
   logic [1:0] cur = 2'd1;
   logic       fire = 1'b0;
   logic       tick = 1'b0;
   logic       up, down, open, tstart;

   int n_chk  = 0;
   int n_fail = 0;
   int ms     = M_IDLE;
   int mcnt   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lift_car_ctrl dut_i (
      .clk(clk), .rst(rst), .req_floor_i(req), .cur_floor_i(cur),
      .fire_i(fire), .tick_i(tick),
      .up_o(up), .down_o(down), .open_o(open), .tstart_o(tstart)
   );

   function automatic int norm(input logic [1:0] v);
      return (v == 2'd0) ? 3 : int'(v);
   endfunction

   function automatic logic [3:0] exp_out(input int s);
      case (s)
         M_UP:    return 4'b1000;
         M_DOWN:  return 4'b0100;
         M_FDESC: return 4'b0100;
         M_DOOR:  return 4'b0011;
         default: return 4'b0010;
      endcase
   endfunction

   function automatic string tag_of(input int s);
      case (s)
         M_IDLE:  return "R2";
         M_UP:    return "R3";
         M_DOWN:  return "R4";
         M_DOOR:  return "R6";
         M_FDESC: return "R8";
         default: return "R9";
      endcase
   endfunction

   function automatic int next_state(input int s, input int rq, input int cf,
                                     input logic f, input int cnt);
      if (f) return (cf == 1) ? M_FHOLD : M_FDESC;
      case (s)
         M_IDLE:  return (rq > cf) ? M_UP : ((rq < cf) ? M_DOWN : M_IDLE);
         M_UP:    return (rq > cf) ? M_UP : M_DOOR;
         M_DOWN:  return (rq < cf) ? M_DOWN : M_DOOR;
         M_DOOR:  return (cnt >= DWELL) ? M_IDLE : M_DOOR;
         default: return M_IDLE;
      endcase
   endfunction

   task automatic check(input string tag, input logic [3:0] expv);
      logic [3:0] act;
      act = {up, down, open, tstart};
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: {up,down,open,tstart} actual=%b expected=%b at %0t", tag, act, expv, $time);
      end
   endtask

   // One clock: update the reference model at the edge, compare at the falling edge.
   task automatic cyc(input string tag);
      int nx;
      @(posedge clk);
      if (rst) begin
         ms = M_IDLE; mcnt = 0;
      end else begin
         nx = next_state(ms, norm(req), norm(cur), fire, mcnt);
         if (nx == M_DOOR && ms != M_DOOR) mcnt = 0;
         else if (ms == M_DOOR && tick && mcnt < 15) mcnt++;
         ms = nx;
      end
      @(negedge clk);
      check((tag == "") ? tag_of(ms) : tag, exp_out(ms));
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int door_len;
      void'($urandom(32'd20250917));
      @(negedge clk);
      cyc("R1"); cyc("R1");
      rst = 1'b0;
      check("R1", 4'b0010);

      // R2: equal floors hold idle
      req = 2'd2; cur = 2'd2;
      repeat (3) cyc("R2");

      // R3 / R5 / R6: upward trip, then dwell with ticks held high
      req = 2'd3; cur = 2'd1;
      cyc("R3");
      cur = 2'd2; cyc("R3");
      cur = 2'd3; tick = 1'b1; cyc("R5");
      door_len = 1;
      for (int i = 0; i < 40; i++) begin
         cyc("R6");
         if (!tstart) break;
         door_len++;
      end
      n_chk++;
      if (door_len != 11) begin
         n_fail++;
         $display("FAIL R6: door cycles actual=%0d expected=11", door_len);
      end

      // R4 / R6: downward trip, door held with no ticks
      tick = 1'b0; req = 2'd1; cur = 2'd3;
      cyc("R4");
      cur = 2'd2; cyc("R4");
      cur = 2'd1; cyc("R5");
      repeat (20) cyc("R6");

      // R8 / R9 / R10: fire from the door state above floor 1
      cur = 2'd3; fire = 1'b1;
      cyc("R8");
      cur = 2'd2; cyc("R9");
      cur = 2'd1; cyc("R9");
      repeat (3) cyc("R9");
      fire = 1'b0; req = 2'd1;
      cyc("R10");

      // R8: fire while already at floor 1 goes straight to hold
      fire = 1'b1; cyc("R8");
      fire = 1'b0; cyc("R10");

      // R11: code 0 is the top floor
      req = 2'd0; cur = 2'd2; cyc("R11");
      cur = 2'd0; cyc("R11");
      cyc("R11");
      fire = 1'b1; cyc("R11");
      fire = 1'b0; cyc("R10");

      // Seeded random mix compared against the model each cycle
      for (int i = 0; i < 6000; i++) begin
         req  = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 2) == 0) cur = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 39) == 0) fire = ~fire;
         tick = ($urandom_range(0, 2) != 0);
         cyc("");
         n_chk++;
         if ((up && down) || (tstart && !open)) begin
            n_fail++;
            $display("FAIL R7: {up,down,open,tstart} actual=%b expected=exclusive", {up, down, open, tstart});
         end
      end

      // Reset mid-run returns to idle
      rst = 1'b1; cyc("R1");
      rst = 1'b0; fire = 1'b0; req = 2'd1; cur = 2'd1;
      cyc("R2");
      finish_run();
   end
endmodule